// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a frame clock and a data line. It turns each frame into one 24-bit left sample and one 24-bit right sample, and presents the pair on a valid/ready output stream. A 3-bit format input selects one of eight framings. The framings differ in four ways:
- the frame-clock level that marks the left channel;
- whether the word is justified to the start or the end of its half-frame;
- whether the word starts one slot after the frame-clock edge;
- which bit-clock edge samples the data.

Words shorter than 24 bits are sign-extended.

All three serial pins are asynchronous to the system clock `clk`, and each passes through a two-flop synchronizer. Each bit-clock phase must last at least three system clocks. Every frame is expected to hold 64 bit-clock periods. A frame-error flag reports any frame of another length. The first frame after reset is used only to find the frame alignment.

On the output stream, a pair is offered with `m_valid` and is held steady until `m_ready` is seen high at a clock edge. The serial link cannot be stalled. If a new pair completes while the previous pair is still waiting, the new pair replaces it and `m_valid` stays high, so the older pair is lost.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` selects the format as follows:
  - 0: 16-bit right-justified
  - 1: 20-bit right-justified
  - 2: 24-bit right-justified
  - 3: 16-bit I2S
  - 4: 20-bit I2S
  - 5: 24-bit I2S
  - 6: 16-bit left-justified
  - 7: 16-bit DSP frame

  A word shorter than 24 bits appears on `m_left`/`m_right` sign-extended from its MSB.
- R2: A frame is 64 bit-clock slots long. Data bits outside the selected word window have no effect on the delivered samples.
- R3: In right-justified formats, the left word is sent while the frame clock is high and the right word while it is low. The word's LSB sits in the last slot of its half, and data is sampled on the rising bit-clock edge.
- R4: In I2S formats, the left word is sent while the frame clock is low and the right word while it is high. The MSB sits in the second slot of the half, one slot after the frame-clock change. Data is sampled on the rising edge.
- R5: In the left-justified format, the left word is sent while the frame clock is high. The MSB sits in the first slot of the half, and data is sampled on the rising edge.
- R6: In the DSP format, data and frame clock are sampled on the falling bit-clock edge. A frame starts at the slot where the sync pulse is first seen high. The left word occupies slots 1 to 16 and the right word slots 17 to 32, both MSB first. Slots 33 to 63 are ignored.
- R7: The first frame after reset is not delivered.
- R8: Each completed frame yields exactly one pair, marked by `m_valid`.
  - In DSP format the pair is offered after slot 32 of the same frame.
  - In all other formats it is offered at the start of the next frame.
- R9: `m_valid` and the data stay unchanged while `m_ready` is low. When a newer pair completes during that wait, it replaces the held pair.
- R10: At every frame start after the first, `frame_err` is updated. It goes high if the number of sampled slots since the previous frame start is not 64, and low otherwise. It holds its value until the next frame start.
- R11: After reset, `m_valid` and `frame_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Serial format code (R1) |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fclk_i | input | 1 | Frame clock or sync pulse, asynchronous |
| sdat_i | input | 1 | Serial data, asynchronous |
| m_valid | output | 1 | Sample pair available |
| m_ready | input | 1 | Consumer accepts the pair |
| m_left | output | 24 | Left sample, sign-extended |
| m_right | output | 24 | Right sample, sign-extended |
| frame_err | output | 1 | Last completed frame was not 64 slots long |

## Verification
Every format code is driven with two consecutive frames.

Each frame carries one negative and one positive word. This separates sign extension from plain zero fill and left steering from right steering.

All unused slots, including the bit just before an I2S MSB and the ignored half of a DSP frame, are filled with ones. Any error in the capture window therefore shows up in the delivered word.

A priming frame with different content confirms that the alignment frame is dropped. Frames of 60 and 68 slots placed between regular frames show that `frame_err` rises and clears at the right frame boundaries. Holding `m_ready` low across two frames shows that the held pair is replaced by the newer one.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [2:0] {
    FMT_RJ16  = 3'd0,
    FMT_RJ20  = 3'd1,
    FMT_RJ24  = 3'd2,
    FMT_I2S16 = 3'd3,
    FMT_I2S20 = 3'd4,
    FMT_I2S24 = 3'd5,
    FMT_LJ16  = 3'd6,
    FMT_DSP16 = 3'd7
  } fmt_e;

  // where the word sits inside its half-frame
  typedef enum logic [1:0] {
    JUST_TRAIL  = 2'd0,  // LSB in last slot of half
    JUST_DELAY1 = 2'd1,  // MSB one slot after frame-clock change
    JUST_LEAD   = 2'd2,  // MSB in first slot of half
    JUST_PULSE  = 2'd3   // sync pulse, both words packed after it
  } just_e;

  localparam int DSP_WORD = 16;

  function automatic just_e fmt_family(fmt_e f);
    case (f)
      FMT_RJ16, FMT_RJ20, FMT_RJ24:    return JUST_TRAIL;
      FMT_I2S16, FMT_I2S20, FMT_I2S24: return JUST_DELAY1;
      FMT_LJ16:                        return JUST_LEAD;
      default:                         return JUST_PULSE;
    endcase
  endfunction

  function automatic logic [4:0] fmt_bits(fmt_e f);
    case (f)
      FMT_RJ20, FMT_I2S20: return 5'd20;
      FMT_RJ24, FMT_I2S24: return 5'd24;
      default:             return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_audio_rx_bitevt.sv
module serial_audio_rx_bitevt
  import serial_audio_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  fmt_e fmt,
  input  logic bclk_s,
  input  logic fclk_s,
  input  logic sdat_s,
  output logic bit_evt,
  output logic bit_val,
  output logic start_evt,
  output logic mid_evt
);
  logic  bclk_d, fs_prev, seen;
  logic  rise, fall, chg, lead_lvl;
  just_e fam;

  always_comb begin
    fam       = fmt_family(fmt);
    rise      = bclk_s & ~bclk_d;
    fall      = ~bclk_s & bclk_d;
    bit_evt   = (fam == JUST_PULSE) ? fall : rise;
    bit_val   = sdat_s;
    lead_lvl  = (fam != JUST_DELAY1);   // frame-clock level of the left half
    chg       = bit_evt && seen && (fclk_s != fs_prev);
    start_evt = chg && (fclk_s == lead_lvl);
    mid_evt   = chg && (fclk_s != lead_lvl) && (fam != JUST_PULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      fs_prev <= 1'b0;
      seen    <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      if (bit_evt) begin
        fs_prev <= fclk_s;
        seen    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx_framer.sv
module serial_audio_rx_framer #(
  parameter int FRAME_BCLKS = 64,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_evt,
  input  logic             start_evt,
  output logic             locked,
  output logic [CNT_W-1:0] slot,
  output logic             frame_err
);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_BCLKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      slot      <= '0;
      frame_err <= 1'b0;
    end else if (start_evt) begin
      if (locked) frame_err <= (slot != LAST_SLOT);
      slot   <= '0;
      locked <= 1'b1;
    end else if (bit_evt && (slot != '1)) begin
      slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/serial_audio_rx_deser.sv
module serial_audio_rx_deser
  import serial_audio_rx_pkg::*;
#(
  parameter int HALF  = 32,
  parameter int OUT_W = 24,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic             bit_evt,
  input  logic             bit_val,
  input  logic             start_evt,
  input  logic             mid_evt,
  input  logic             locked,
  input  logic [CNT_W-1:0] slot,
  output logic             pub,
  output logic [OUT_W-1:0] pub_left,
  output logic [OUT_W-1:0] pub_right
);
  localparam int SW = $clog2(HALF);
  localparam logic [CNT_W-1:0] DSP_LAST = CNT_W'(2 * DSP_WORD - 1);

  logic [HALF-1:0]  sh, sh_nx;
  logic [OUT_W-1:0] left_hold, word_now;
  logic             left_ok;
  logic [SW-1:0]    msb;
  logic [4:0]       nbits;
  just_e            fam;

  // align the word MSB to the top, then arithmetic-shift it down
  function automatic logic [OUT_W-1:0] take(input logic [HALF-1:0] src,
                                            input logic [SW-1:0] top_bit,
                                            input logic [4:0] len);
    logic [HALF-1:0]         al;
    logic signed [OUT_W-1:0] tp;
    al = src << (SW'(HALF - 1) - top_bit);
    tp = al[HALF-1 -: OUT_W];
    return OUT_W'(tp >>> (OUT_W - int'(len)));
  endfunction

  always_comb begin
    fam   = fmt_family(fmt);
    nbits = fmt_bits(fmt);
    sh_nx = {sh[HALF-2:0], bit_val};
    case (fam)
      JUST_TRAIL:  msb = SW'(nbits - 5'd1);
      JUST_DELAY1: msb = SW'(HALF - 2);
      default:     msb = SW'(HALF - 1);
    endcase
    word_now  = take(sh, msb, nbits);
    pub       = 1'b0;
    pub_left  = left_hold;
    pub_right = word_now;
    if (fam == JUST_PULSE) begin
      if (bit_evt && locked && !start_evt && (slot == DSP_LAST)) begin
        pub       = 1'b1;
        pub_left  = take(sh_nx, SW'(HALF - 1), nbits);
        pub_right = take(sh_nx, SW'(HALF - 1 - DSP_WORD), nbits);
      end
    end else if (start_evt && left_ok) begin
      pub = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      left_hold <= '0;
      left_ok   <= 1'b0;
    end else begin
      if (bit_evt) sh <= sh_nx;
      if (mid_evt && locked && (fam != JUST_PULSE)) begin
        left_hold <= word_now;
        left_ok   <= 1'b1;
      end else if (start_evt) begin
        left_ok <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int FRAME_BCLKS = 64,
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt_sel,
  input  logic             bclk_i,
  input  logic             fclk_i,
  input  logic             sdat_i,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OUT_W-1:0] m_left,
  output logic [OUT_W-1:0] m_right,
  output logic             frame_err
);
  localparam int HALF  = FRAME_BCLKS / 2;
  localparam int CNT_W = $clog2(FRAME_BCLKS) + 1;

  fmt_e             fmt;
  logic [2:0]       pins_s;
  logic             bit_evt, bit_val, start_evt, mid_evt, locked, pub;
  logic [CNT_W-1:0] slot;
  logic [OUT_W-1:0] pub_left, pub_right;

  assign fmt = fmt_e'(fmt_sel);

  serial_audio_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({bclk_i, fclk_i, sdat_i}), .q(pins_s)
  );

  serial_audio_rx_bitevt u_bitevt (
    .clk(clk), .rst_n(rst_n), .fmt(fmt),
    .bclk_s(pins_s[2]), .fclk_s(pins_s[1]), .sdat_s(pins_s[0]),
    .bit_evt(bit_evt), .bit_val(bit_val), .start_evt(start_evt), .mid_evt(mid_evt)
  );

  serial_audio_rx_framer #(.FRAME_BCLKS(FRAME_BCLKS), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .start_evt(start_evt),
    .locked(locked), .slot(slot), .frame_err(frame_err)
  );

  serial_audio_rx_deser #(.HALF(HALF), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .bit_evt(bit_evt), .bit_val(bit_val),
    .start_evt(start_evt), .mid_evt(mid_evt), .locked(locked), .slot(slot),
    .pub(pub), .pub_left(pub_left), .pub_right(pub_right)
  );

  // output stage: newest pair wins while waiting for the consumer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_left  <= '0;
      m_right <= '0;
    end else if (pub) begin
      m_valid <= 1'b1;
      m_left  <= pub_left;
      m_right <= pub_right;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       fmt_sel,
  input logic             m_valid,
  input logic             m_ready,
  input logic [OUT_W-1:0] m_left,
  input logic [OUT_W-1:0] m_right,
  input logic             frame_err,
  input logic             pub,
  input logic             start_evt,
  input logic             locked
);
  logic is16;
  assign is16 = (fmt_sel == 3'd0) || (fmt_sel == 3'd3) || (fmt_sel == 3'd6) || (fmt_sel == 3'd7);

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid);

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready && !pub |=> $stable(m_left) && $stable(m_right));

  // R8
  offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub |=> m_valid);

  // R8
  drop_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !pub |=> !m_valid);

  // R10
  err_only_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(frame_err));

  // R7
  no_pair_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !pub);

  // R1
  sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pub && is16 |=> (m_left[OUT_W-1:15] == '0) || (m_left[OUT_W-1:15] == '1));
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .m_valid(m_valid), .m_ready(m_ready),
  .m_left(m_left), .m_right(m_right), .frame_err(frame_err), .pub(pub),
  .start_evt(start_evt), .locked(locked)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        bclk_i = 1'b0, fclk_i = 1'b0, sdat_i = 1'b0;
  logic        m_ready = 1'b1;
  logic        m_valid, frame_err;
  logic [23:0] m_left, m_right;

  int n_chk = 0, n_fail = 0, cap_n = 0;
  logic [23:0] cap_l [8];
  logic [23:0] cap_r [8];

  always #5 clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .bclk_i(bclk_i), .fclk_i(fclk_i),
    .sdat_i(sdat_i), .m_valid(m_valid), .m_ready(m_ready), .m_left(m_left),
    .m_right(m_right), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && cap_n < 8) begin
      cap_l[cap_n] = m_left;
      cap_r[cap_n] = m_right;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wlen(input int m);
    if (m == 1 || m == 4) return 20;
    if (m == 2 || m == 5) return 24;
    return 16;
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] w, input int n);
    if (n == 16) return {{8{w[15]}}, w[15:0]};
    if (n == 20) return {{4{w[19]}}, w[19:0]};
    return w;
  endfunction

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0; bclk_i = 1'b0; fclk_i = 1'b0; sdat_i = 1'b0; fmt_sel = 3'(m);
    cap_n = 0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // one slot: change data at the non-sampling edge, sample edge half a slot later
  task automatic drive_slot(input logic b, input logic f, input logic dsp);
    @(negedge clk);
    bclk_i = dsp; sdat_i = b; fclk_i = f;
    repeat (4) @(negedge clk);
    bclk_i = ~dsp;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int m, input logic [23:0] l, input logic [23:0] r,
                            input int nsl, input logic pad);
    int half = nsl / 2;
    int n = wlen(m);
    for (int s = 0; s < nsl; s++) begin
      int p = (s < half) ? s : s - half;
      logic [23:0] w = (s < half) ? l : r;
      logic b = pad;
      logic f;
      if (m <= 2) begin
        f = (s < half);
        if (p >= half - n) b = w[half - 1 - p];
      end else if (m <= 5) begin
        f = (s >= half);
        if (p >= 1 && p <= n) b = w[n - p];
      end else if (m == 6) begin
        f = (s < half);
        if (p < 16) b = w[15 - p];
      end else begin
        f = (s == 0);
        if (s >= 1 && s <= 16) b = l[16 - s];
        else if (s >= 17 && s <= 32) b = r[32 - s];
      end
      drive_slot(b, f, m == 7);
    end
  endtask

  task automatic send_lead(input int m);
    drive_slot(1'b0, (m >= 3 && m <= 5) ? 1'b0 : 1'b1, m == 7);
    repeat (10) @(negedge clk);
  endtask

  task automatic test_reset;
    do_reset(0);
    check("R11 valid after reset", {23'd0, m_valid}, 24'd0);
    check("R11 frame_err after reset", {23'd0, frame_err}, 24'd0);
  endtask

  // two frames per format, padding forced to ones (R2), prime frame dropped (R7)
  task automatic test_format(input int m, input string req, input logic [23:0] l1,
                             input logic [23:0] r1);
    int n = wlen(m);
    logic [23:0] mask = 24'((1 << n) - 1);
    logic [23:0] l2 = ~l1 & mask;
    logic [23:0] r2 = ~r1 & mask;
    do_reset(m);
    send_frame(m, 24'h5A5A5A & mask, 24'h3C3C3C & mask, 64, 1'b1);
    send_frame(m, l1, r1, 64, 1'b1);
    send_frame(m, l2, r2, 64, 1'b1);
    send_lead(m);
    check({req, " R7 R8 pair count"}, 24'(cap_n), 24'd2);
    check({req, " R1 R2 left 1"},  cap_l[0], sx(l1, n));
    check({req, " R1 R2 right 1"}, cap_r[0], sx(r1, n));
    check({req, " R1 left 2"},     cap_l[1], sx(l2, n));
    check({req, " R1 right 2"},    cap_r[1], sx(r2, n));
  endtask

  task automatic test_frame_err;
    do_reset(2);
    send_frame(2, 24'h1, 24'h2, 64, 1'b0);
    send_frame(2, 24'h3, 24'h4, 64, 1'b0);
    send_frame(2, 24'h5, 24'h6, 60, 1'b0);
    check("R10 after regular frame", {23'd0, frame_err}, 24'd0);
    send_frame(2, 24'h7, 24'h8, 64, 1'b0);
    check("R10 short frame flagged", {23'd0, frame_err}, 24'd1);
    send_frame(2, 24'h9, 24'hA, 68, 1'b0);
    check("R10 flag cleared", {23'd0, frame_err}, 24'd0);
    send_frame(2, 24'hB, 24'hC, 64, 1'b0);
    check("R10 long frame flagged", {23'd0, frame_err}, 24'd1);
    send_lead(2);
    check("R10 flag cleared again", {23'd0, frame_err}, 24'd0);
  endtask

  task automatic test_backpressure;
    do_reset(2);
    m_ready = 1'b0;
    send_frame(2, 24'h000111, 24'h000222, 64, 1'b0);
    send_frame(2, 24'h111111, 24'h222222, 64, 1'b0);
    send_frame(2, 24'h333333, 24'h444444, 64, 1'b0);
    send_lead(2);
    check("R9 valid held", {23'd0, m_valid}, 24'd1);
    check("R9 newest left kept", m_left, 24'h333333);
    check("R9 newest right kept", m_right, 24'h444444);
    check("R9 nothing taken", 24'(cap_n), 24'd0);
    @(negedge clk);
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 one pair taken", 24'(cap_n), 24'd1);
    check("R9 taken left", cap_l[0], 24'h333333);
    check("R8 valid drops", {23'd0, m_valid}, 24'd0);
  endtask

  initial begin
    test_reset();
    test_format(0, "R3 rj16", 24'h008001, 24'h001234);
    test_format(1, "R3 rj20", 24'h080F0A, 24'h05A5A5);
    test_format(2, "R3 rj24", 24'hA5C33C, 24'h123456);
    test_format(3, "R4 i2s16", 24'h007FFF, 24'h00C000);
    test_format(4, "R4 i2s20", 24'h09ABCD, 24'h001234);
    test_format(5, "R4 i2s24", 24'h800000, 24'h7FFFFE);
    test_format(6, "R5 lj16", 24'h00BEEF, 24'h000F0F);
    test_format(7, "R6 dsp16", 24'h008421, 24'h007BDE);
    test_frame_err();
    test_backpressure();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule